// File: doc/BRIEF.md
# PCI configuration address generator

This block converts a configuration request into the two values a host bridge needs before it can run a configuration cycle through a 16 MB configuration aperture. A request consists of a bus number, a combined device/function number (slot in bits 7:3, function in bits 2:0) and a register offset. The first result is the low address to use inside the aperture. The second result is a 16-bit value for the window's map register. That value selects the configuration cycle type and supplies any address bits that lie above the aperture.

Requests on bus 0 are type 0. For these the device is selected by a single one-hot address line. When that line would fall beyond the top of the 24-bit aperture, it is moved into the map value instead. Requests on any other bus are type 1 and are encoded as a bus/device/function address.

Requests are accepted with a valid/ready handshake. The result appears registered one cycle after acceptance and is held until the consumer takes it. A request the block cannot encode produces an error result instead of a valid one.

Top module: `cfg_addr_gen`

## Requirements
- R1: A request with bus number 0 is type 0 and gives map value bit 0 = 0. Any nonzero bus number is type 1 and gives map value bit 0 = 1.
- R2: Every valid result has map value bits 3:1 = 3'b101. A type 1 result has map value bits 15:4 = 0, so its map value is 16'h000B.
- R3: In a type 0 result, the function number (devfn bits 2:0) sits in address bits 10:8 and the register offset sits in address bits 7:0.
- R4: In a type 0 result with slot 0 to 12, address bit (slot + 11) is the only set bit among address bits 23:11. Map value bits 15:4 are 0, so the map value is 16'h000A.
- R5: In a type 0 result with slot 13 to 20, map value bit (slot − 5) is the only set bit among map value bits 15:4. Address bits 23:11 are all 0.
- R6: A type 1 result has an address equal to (bus << 16) | (devfn << 8) | offset.
- R7: A request is illegal if its bus number, devfn or offset exceeds 255, or if it is type 0 with slot above 20. An illegal request gives cfg_err = 1, cfg_valid = 0, and an address and map value of 0.
- R8: A request accepted at a clock edge (req_valid and req_ready both high) shows its result from that edge on. The result and its flag are held while rsp_ready is low. While the result is held, req_ready is low.
- R9: After reset, cfg_valid = 0, cfg_err = 0 and req_ready = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| bus_num | input | IN_W (16) | Requested bus number |
| devfn | input | IN_W (16) | Slot in bits 7:3, function in bits 2:0 |
| reg_off | input | IN_W (16) | Configuration register offset |
| rsp_ready | input | 1 | Consumer takes the current result |
| cfg_valid | output | 1 | A legal result is held |
| cfg_err | output | 1 | An illegal request's result is held |
| aper_addr | output | APER_W (24) | Address inside the configuration aperture |
| map_val | output | MAP_W (16) | Value for the window map register |

## Verification
Type 0 requests are tried at slots 0, 5 and 12 and at slots 13, 17 and 20. These show whether the select bit moves from the address to the map value exactly at the 12/13 boundary, and whether it lands at the right shifted position on each side. Type 1 requests use bus numbers 1 and 255 with varied devfn and offset. These show that the full devfn is packed unchanged and that the low-address-enable bit differs from type 0. Illegal requests include each out-of-range field on its own and type 0 slots 21 and 31; these show that each check acts alone. A stalled consumer then shows that the result is held and that req_ready drops while the result waits.

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int IN_W    = 16,
  parameter int APER_W  = 24,
  parameter int MAP_W   = 16,
  parameter int FIELD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IN_W-1:0]   bus_num,
  input  logic [IN_W-1:0]   devfn,
  input  logic [IN_W-1:0]   reg_off,
  input  logic              rsp_ready,
  output logic              cfg_valid,
  output logic              cfg_err,
  output logic [APER_W-1:0] aper_addr,
  output logic [MAP_W-1:0]  map_val
);
  localparam int SEL_BASE  = 11;
  localparam int MAP_SHIFT = 5;
  localparam int LOW_MAX   = APER_W - 1 - SEL_BASE;
  localparam int HIGH_MAX  = MAP_W - 1 + MAP_SHIFT;
  localparam logic [MAP_W-1:0] CODE_T0 = MAP_W'(4'b1010);
  localparam logic [MAP_W-1:0] CODE_T1 = MAP_W'(4'b1011);

  logic              type1;
  logic [4:0]        slot;
  logic              slot_low;
  logic              illegal;
  logic              accept;
  logic [APER_W-1:0] nxt_addr;
  logic [MAP_W-1:0]  nxt_map;

  assign type1    = |bus_num;
  assign slot     = devfn[7:3];
  assign slot_low = 32'(slot) <= LOW_MAX;
  assign illegal  = (|bus_num[IN_W-1:FIELD_W]) | (|devfn[IN_W-1:FIELD_W])
                  | (|reg_off[IN_W-1:FIELD_W]) | (!type1 && 32'(slot) > HIGH_MAX);
  assign req_ready = !(cfg_valid || cfg_err) || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (type1) begin
      nxt_addr = APER_W'({bus_num[7:0], devfn[7:0], reg_off[7:0]});
      nxt_map  = CODE_T1;
    end else begin
      nxt_addr = APER_W'({devfn[2:0], reg_off[7:0]});
      nxt_map  = CODE_T0;
      if (slot_low) nxt_addr = nxt_addr | (APER_W'(1) << (32'(slot) + SEL_BASE));
      else          nxt_map  = nxt_map  | (MAP_W'(1) << (32'(slot) - MAP_SHIFT));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
      cfg_err   <= 1'b0;
      aper_addr <= '0;
      map_val   <= '0;
    end else if (accept) begin
      cfg_valid <= !illegal;
      cfg_err   <= illegal;
      aper_addr <= illegal ? '0 : nxt_addr;
      map_val   <= illegal ? '0 : nxt_map;
    end else if (rsp_ready) begin
      cfg_valid <= 1'b0;
      cfg_err   <= 1'b0;
    end
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_err));
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (aper_addr == '0 && map_val == '0));
  a_r2_type_code: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> map_val[3:1] == 3'b101);
  a_r2_type1_map: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && map_val[0]) |-> map_val[MAP_W-1:4] == '0);
  a_r4_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !map_val[0]) |->
      $countones({aper_addr[APER_W-1:SEL_BASE], map_val[MAP_W-1:4]}) == 1);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_valid || cfg_err) && !rsp_ready) |=>
      ($stable(aper_addr) && $stable(map_val) && $stable(cfg_valid) && $stable(cfg_err)));
  a_r8_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_valid || cfg_err) && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/cfg_addr_gen_tb.sv
module cfg_addr_gen_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [15:0] bus_num = 0, devfn = 0, reg_off = 0;
  logic        rsp_ready = 1;
  logic        cfg_valid, cfg_err;
  logic [23:0] aper_addr;
  logic [15:0] map_val;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .bus_num(bus_num), .devfn(devfn), .reg_off(reg_off), .rsp_ready(rsp_ready),
    .cfg_valid(cfg_valid), .cfg_err(cfg_err), .aper_addr(aper_addr), .map_val(map_val)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] b, input logic [15:0] d, input logic [15:0] o);
    @(negedge clk);
    bus_num = b; devfn = d; reg_off = o; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_ok(input string tag, input logic [23:0] ea, input logic [15:0] em);
    check({tag, " valid"}, {cfg_err, cfg_valid}, 2'b01);
    check({tag, " addr"}, aper_addr, ea);
    check({tag, " map"}, map_val, em);
  endtask

  task automatic expect_err(input string tag);
    check({tag, " flags"}, {cfg_err, cfg_valid}, 2'b10);
    check({tag, " addr"}, aper_addr, 0);
    check({tag, " map"}, map_val, 0);
  endtask

  task automatic t_reset;
    check("R9 reset flags", {req_ready, cfg_err, cfg_valid}, 3'b100);
  endtask

  task automatic t_type0_low;
    int slots[3] = '{0, 5, 12};
    foreach (slots[i]) begin
      logic [15:0] d = 16'((slots[i] << 3) | 3);
      issue(0, d, 16'h3C);
      expect_ok("R1 R3 R4 type0 low", 24'(1 << (slots[i] + 11)) | 24'h00033C, 16'h000A);
    end
  endtask

  task automatic t_type0_high;
    int slots[3] = '{13, 17, 20};
    foreach (slots[i]) begin
      logic [15:0] d = 16'((slots[i] << 3) | 5);
      issue(0, d, 16'hFF);
      expect_ok("R1 R3 R5 type0 high", 24'h0005FF, 16'h000A | 16'(1 << (slots[i] - 5)));
    end
  endtask

  task automatic t_type1;
    issue(1, 16'h00A9, 16'h10);
    expect_ok("R1 R2 R6 type1 bus1", 24'h01A910, 16'h000B);
    issue(255, 16'h00FF, 16'hFF);
    expect_ok("R2 R6 type1 bus255", 24'hFFFFFF, 16'h000B);
    issue(16'h37, 16'h00F8, 16'h00);
    expect_ok("R6 type1 slot31", 24'h37F800, 16'h000B);
  endtask

  task automatic t_illegal;
    issue(16'h0100, 16'h08, 0);   expect_err("R7 bus over");
    issue(1, 16'h0100, 0);        expect_err("R7 devfn over");
    issue(0, 16'h08, 16'h0100);   expect_err("R7 offset over");
    issue(0, 16'(21 << 3), 0);    expect_err("R7 slot21");
    issue(0, 16'(31 << 3), 4);    expect_err("R7 slot31");
    issue(0, 16'h08, 4);
    expect_ok("R7 recovery", 24'h001004, 16'h000A);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 0;
    bus_num = 2; devfn = 16'h11; reg_off = 16'h20; req_valid = 1;
    @(negedge clk);
    expect_ok("R8 first", 24'h021120, 16'h000B);
    bus_num = 0; devfn = 16'h00; reg_off = 16'h04;
    check("R8 ready low", req_ready, 0);
    @(negedge clk);
    expect_ok("R8 held", 24'h021120, 16'h000B);
    check("R8 ready still low", req_ready, 0);
    rsp_ready = 1;
    #0.1;
    check("R8 ready on drain", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    expect_ok("R8 second", 24'h000804, 16'h000A);
    @(negedge clk);
    check("R8 drained", {cfg_err, cfg_valid}, 2'b00);
  endtask

  initial begin
    #1;
    t_reset;
    #10 rst_n = 1;
    t_type0_low;
    t_type0_high;
    t_type1;
    t_illegal;
    t_backpressure;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule